// File: doc/BRIEF.md
# Open-Drain Reset Line Manual-Press Detector

This block owns a shared, active-low reset line that is pulled high by a weak resistor. Two things can pull the line low: the block, through its drive-enable output, and any outside agent, such as a pushbutton to ground. The block reads the line back as a digital level. It has to tell its own pulldown apart from an outside one.

A low that the block did not cause is a manual reset request. A press counts only after the sensed level has stayed low for a full debounce period. While the outside agent holds the line, the block keeps its own drive off, which lets it see the release. Once the release has been debounced, the block drives the line low itself for a manual-reset timeout. One input picks a short or a long timeout.

An internal reset request, for example from supply monitors, drives the line at once. Lows seen while the block drives the line never count as presses. After any drive of its own ends, a short settle window passes before press detection starts again.

Top module: `mrd_pin_reset`

## Requirements
- R1: While the synchronous reset `rst` is high and on the first cycles after it, `pin_drive_o` is 0 and no press is being tracked.
- R2: `rst_req_i` sampled high at a clock edge makes `pin_drive_o` 1 after that edge. The drive lasts exactly as many cycles as the request, and the low it puts on the line never leads to a manual-reset pulse afterwards.
- R3: A press is recognised only after the synchronised line level (SYNC_STAGES flops) has been low on DEB_CYC consecutive sampling edges. An outside low lasting DEB_CYC-1 cycles produces no drive. One lasting DEB_CYC cycles is accepted.
- R4: While an accepted press is still held, `pin_drive_o` stays 0. The line is low only through the outside agent.
- R5: After the release, the manual drive rises on the (SYNC_STAGES+DEB_CYC)-th clock edge, counting as edge 1 the first edge that samples the line high.
- R6: The manual drive lasts exactly MR_SHORT_CYC cycles when `mr_long_i` is 0 and MR_LONG_CYC cycles when it is 1. The value is sampled at the edge where the hold starts.
- R7: Any change of the synchronised level during a debounce restarts the count. A bouncing press followed by a bouncing release yields exactly one manual pulse, timed from the last release edge.
- R8: After every drive of the block's own ends, the sensed level is ignored for SETTLE_CYC cycles. Only samples taken after that window count towards a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Internal reset request; drive the line while high |
| mr_long_i | input | 1 | Timeout select: 0 short, 1 long |
| pin_lvl_i | input | 1 | Sensed level of the reset line (1 = high) |
| pin_drive_o | output | 1 | Drive-enable of the line pulldown (1 = pull low) |

## Verification
If the debounce counter is stuck or off by one, short glitches come out as full manual pulses, or presses of exactly the debounce length are lost. Either shows on the drive-enable within one debounce period after the low. If the state register wrongly treats the block's own drive as a press, an extra manual pulse follows the request or the settle window, about SYNC_STAGES+DEB_CYC cycles after the drive ends. A wrong timer load shows as a pulse of the wrong length, so every pulse's start cycle and width are compared against values worked out from the release time.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRESS  = 3'd1,
    ST_HOLD   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_OWN    = 3'd4
  } mrd_state_e;
endpackage

// File: rtl/mrd_sync.sv
module mrd_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  if (STAGES > 1) begin : g_multi
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d};
    end
  end else begin : g_single
    always_ff @(posedge clk) begin
      if (rst) chain <= RST_VAL;
      else     chain <= d;
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mrd_debounce.sv
module mrd_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic want,
  input  logic lvl,
  output logic hit
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [CW-1:0] cnt;
  logic          match;

  assign match = en && (lvl == want);
  assign hit   = match && (cnt == CW'(DEB_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !match || hit) cnt <= '0;
    else                      cnt <= cnt + CW'(1);
  end

  // R7: a level that differs from the target restarts the stability count
  a_r7_restart_on_change: assert property (@(posedge clk) disable iff (rst)
    (en && (lvl != want)) |=> (cnt == '0));

  // R3: a hit is only possible after a cycle that already matched the target
  a_r3_hit_after_match: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(en && (lvl == want)));
endmodule

// File: rtl/mrd_timer.sv
module mrd_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= len - TW'(1);
    else if (cnt != '0)   cnt <= cnt - TW'(1);
  end

  assign last = (cnt == '0);

  // R6: once loaded, the count falls by exactly one each cycle
  a_r6_timer_step: assert property (@(posedge clk) disable iff (rst)
    (!start && (cnt != '0)) |=> (cnt == $past(cnt) - TW'(1)));
endmodule

// File: rtl/mrd_pin_reset.sv
module mrd_pin_reset
  import mrd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DEB_CYC      = 16,
  parameter int MR_SHORT_CYC = 64,
  parameter int MR_LONG_CYC  = 512,
  parameter int SETTLE_CYC   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_req_i,
  input  logic mr_long_i,
  input  logic pin_lvl_i,
  output logic pin_drive_o
);
  localparam int MAX_A = (MR_LONG_CYC > MR_SHORT_CYC) ? MR_LONG_CYC : MR_SHORT_CYC;
  localparam int TMAX  = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  mrd_state_e    state, nxt;
  logic          lvl;
  logic          deb_en, deb_want, deb_hit;
  logic          tmr_start, tmr_last;
  logic [TW-1:0] tmr_len;
  logic          drive_q;

  mrd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_lvl_i),
    .q   (lvl)
  );

  assign deb_en   = (state == ST_IDLE) || (state == ST_PRESS);
  assign deb_want = (state == ST_PRESS);

  mrd_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk  (clk),
    .rst  (rst),
    .en   (deb_en),
    .want (deb_want),
    .lvl  (lvl),
    .hit  (deb_hit)
  );

  mrd_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  always_comb begin
    nxt       = state;
    tmr_start = 1'b0;
    tmr_len   = TW'(SETTLE_CYC);
    case (state)
      ST_IDLE: begin
        if (deb_hit) nxt = ST_PRESS;
      end
      ST_PRESS: begin
        if (deb_hit) begin
          nxt       = ST_HOLD;
          tmr_start = 1'b1;
          tmr_len   = mr_long_i ? TW'(MR_LONG_CYC) : TW'(MR_SHORT_CYC);
        end
      end
      ST_HOLD: begin
        if (tmr_last) begin
          nxt       = rst_req_i ? ST_OWN : ST_SETTLE;
          tmr_start = !rst_req_i;
        end
      end
      ST_SETTLE: begin
        if (tmr_last) nxt = ST_IDLE;
      end
      ST_OWN: begin
        if (!rst_req_i) begin
          nxt       = ST_SETTLE;
          tmr_start = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (rst_req_i && (state != ST_HOLD)) begin
      nxt       = ST_OWN;
      tmr_start = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      state   <= nxt;
      drive_q <= rst_req_i || (nxt == ST_HOLD);
    end
  end

  assign pin_drive_o = drive_q;

  // R2: an internal request pulls the line on the following cycle
  a_r2_req_drives: assert property (@(posedge clk) disable iff (rst)
    rst_req_i |=> pin_drive_o);

  // R2: the block's own drive never turns into a press
  a_r2_own_not_press: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OWN) |=> (state != ST_PRESS));

  // R4: no drive from the block while a press is held
  a_r4_quiet_in_press: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_PRESS) && !$past(rst_req_i)) |-> !pin_drive_o);

  // R5: a drive not caused by a request starts only from a held press
  a_r5_rise_from_press: assert property (@(posedge clk) disable iff (rst)
    ($rose(pin_drive_o) && !$past(rst_req_i)) |-> ($past(state) == ST_PRESS));

  // R8: the settle window cannot jump straight into press tracking
  a_r8_settle_exit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |=> ((state == ST_SETTLE) || (state == ST_IDLE) || (state == ST_OWN)));
endmodule

// File: tb/mrd_pin_reset_tb.sv
module mrd_pin_reset_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC   = 2;
  localparam int DEB    = 16;
  localparam int SHORT  = 64;
  localparam int LONG   = 512;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_req = 1'b0;
  logic mr_long = 1'b0;
  logic ext_low = 1'b0;
  logic drive;
  logic pin;

  assign pin = !(drive || ext_low);

  mrd_pin_reset #(
    .SYNC_STAGES(SYNC), .DEB_CYC(DEB), .MR_SHORT_CYC(SHORT),
    .MR_LONG_CYC(LONG), .SETTLE_CYC(SETTLE)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .rst_req_i   (rst_req),
    .mr_long_i   (mr_long),
    .pin_lvl_i   (pin),
    .pin_drive_o (drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    start;
    int    len;
    string req;
  } pulse_t;

  pulse_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int start, int len, string req);
    pulse_t p;
    p.start = start;
    p.len   = len;
    p.req   = req;
    exp_q.push_back(p);
  endtask

  // monitor: measures every drive pulse and compares with the queue
  initial begin
    bit     prev;
    int     st;
    pulse_t e;
    prev = 1'b0;
    st   = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        prev = 1'b0;
        continue;
      end
      if (drive && !prev) st = cyc;
      if (!drive && prev) begin
        pulses++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R8", "unexpected pulse at cycle", st, -1);
        end else begin
          e = exp_q.pop_front();
          check(st == e.start, e.req, "pulse start cycle", st, e.start);
          check((cyc - st) == e.len, e.req, "pulse length", cyc - st, e.len);
        end
      end
      prev = drive;
    end
  end

  task automatic req_pulse(int n, string req);
    rst_req = 1'b1;
    push(cyc + 1, n, req);
    wait_cyc(n);
    rst_req = 1'b0;
  endtask

  task automatic press(int hold, bit lng, string req, bit expect_pulse);
    int nz;
    int len;
    nz      = 0;
    len     = lng ? LONG : SHORT;
    mr_long = lng;
    ext_low = 1'b1;
    repeat (hold) begin
      @(negedge clk);
      if (drive) nz++;
    end
    ext_low = 1'b0;
    if (expect_pulse) push(cyc + SYNC + DEB, len, req);
    check(nz == 0, "R4", "drive cycles during press", nz, 0);
    wait_cyc(SYNC + DEB + len + SETTLE + 6);
  endtask

  task automatic bounce_press();
    mr_long = 1'b0;
    ext_low = 1'b1; wait_cyc(3);
    ext_low = 1'b0; wait_cyc(2);
    ext_low = 1'b1; wait_cyc(5);
    ext_low = 1'b0; wait_cyc(1);
    ext_low = 1'b1; wait_cyc(DEB + 6);
    ext_low = 1'b0; wait_cyc(3);
    ext_low = 1'b1; wait_cyc(2);
    ext_low = 1'b0; wait_cyc(4);
    ext_low = 1'b1; wait_cyc(1);
    ext_low = 1'b0;
    push(cyc + SYNC + DEB, SHORT, "R7");
    wait_cyc(SYNC + DEB + SHORT + SETTLE + 6);
  endtask

  task automatic settle_case(int l, bit expect_pulse, string req);
    mr_long = 1'b0;
    req_pulse(10, "R2");
    ext_low = 1'b1;
    wait_cyc(l);
    ext_low = 1'b0;
    if (expect_pulse) push(cyc + SYNC + DEB, SHORT, req);
    wait_cyc(SYNC + DEB + SHORT + SETTLE + 6);
  endtask

  initial begin
    int p0;
    wait_cyc(3);
    check(drive == 1'b0, "R1", "drive during reset", drive, 0);
    rst = 1'b0;
    wait_cyc(5);
    check(drive == 1'b0, "R1", "drive after reset", drive, 0);

    // R2: short and long internal requests, no press after own low
    req_pulse(7, "R2");
    wait_cyc(20);
    p0 = pulses;
    req_pulse(3 * DEB, "R2");
    wait_cyc(DEB + SETTLE + SYNC + 20);
    check(pulses == p0 + 1, "R2", "pulses after long request", pulses, p0 + 1);

    // R3: one cycle short of the debounce is ignored, exact length is accepted
    p0 = pulses;
    press(DEB - 1, 1'b0, "R3", 1'b0);
    check(pulses == p0, "R3", "pulses after short low", pulses, p0);
    press(DEB, 1'b0, "R3", 1'b1);

    // R5 / R6: both timeout options
    press(3 * DEB, 1'b0, "R6", 1'b1);
    press(40, 1'b1, "R5", 1'b1);

    // R7: bouncing press and release
    p0 = pulses;
    bounce_press();
    check(pulses == p0 + 1, "R7", "pulses after bouncy press", pulses, p0 + 1);

    // R8: low kept over the drive release, too short once the settle window is skipped
    p0 = pulses;
    settle_case(DEB + SETTLE - 2, 1'b0, "R8");
    check(pulses == p0 + 1, "R8", "pulses after settle-window low", pulses, p0 + 1);
    p0 = pulses;
    settle_case(DEB + SETTLE + 3, 1'b1, "R8");
    check(pulses == p0 + 2, "R8", "pulses after long held low", pulses, p0 + 2);

    wait_cyc(20);
    check(exp_q.size() == 0, "R6", "pulses still expected", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule